// File: doc/BRIEF.md
# Bidirectional GPIO Port with Reset-Retained Outputs

This block controls one bidirectional I/O port of `WIDTH` pins (8 by default) through a small register bus. Three registers set the port up: a direction register (bit = 1 makes the pin an output), an output data register, and a pull-up register. For every pin the block drives an output value, an output enable and a weak pull-up enable toward the pad. Reading the pin address returns a mixed view. Output pins show their data register bit. Input pins show the pad level after a two-flop synchronizer, and pins picked by a mask also pass through a debounce filter.

The pull-up enable comes from one of two sources, chosen by a parameter. One source is the pull-up register. The other is the output data bit, and in that case the pull-up register does not exist. Either way, the pull-up is on only for pins in input mode. The reset is synchronous and active low, and a companion input gives its cause. A power-on reset clears every register. A port built as retain-capable keeps its direction, data and pull-up registers through a reset caused by a watchdog overflow, so the pins hold their driven state. A port that is not retain-capable clears on both kinds of reset.

Top module: `gpio_retain_port`

## Requirements
- R1: A reset with `rst_wdt` = 0 (power-on) clears the direction, data and pull-up registers, so `pad_oe`, `pad_out` and `pad_pu` are 0 and the register reads at addresses 0, 1 and 2 return 0.
- R2: With `RETAIN` = 1, a reset with `rst_wdt` = 1 leaves the direction, data and pull-up registers unchanged. With `RETAIN` = 0, the same reset clears them as in R1.
- R3: A write at address 0 sets the direction register, at address 1 the data register, and at address 2 the pull-up register. A read at each of these addresses returns the stored value in the same cycle.
- R4: `pad_oe` equals the direction register and `pad_out` equals the data register, one clock after the write.
- R5: With `PULL_MODE` = 0, `pad_pu` = ~direction & pull-up register, so a pin with `pad_oe` = 1 never has `pad_pu` = 1.
- R6: With `PULL_MODE` = 1, `pad_pu` = ~direction & data register. No pull-up register exists: writes at address 2 have no effect and reads at address 2 return 0.
- R7: Address 3 is read-only. A write there changes no register and no pad output.
- R8: A read at address 3 returns, per pin, the data register bit when the direction bit is 1. Otherwise it returns the pad level, which appears after two clock edges for pins outside `DEB_MASK`.
- R9: A pin in `DEB_MASK` (default upper four pins) takes on a new input level only after the synchronized level has matched it on `DEB_COUNT` (default 4) consecutive sample ticks, one tick every `TICK_DIV` (default 4) clocks. A pulse spanning fewer ticks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_wdt | input | 1 | Reset cause: 1 = watchdog overflow, 0 = power-on |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 direction, 1 data, 2 pull-up, 3 pin |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for `bus_addr` (combinational) |
| pad_in | input | WIDTH | Raw pad levels |
| pad_out | output | WIDTH | Output value toward the pads |
| pad_oe | output | WIDTH | Output enable per pin |
| pad_pu | output | WIDTH | Weak pull-up enable per pin |

## Verification
The assertions assume that `rst_wdt` is a defined level whenever `rst_n` is low. They also assume that a write at the pin address is a single-cycle strobe with no competing write, because the bus has only one write port. The stimulus always drives `rst_wdt` to 0 or 1 before it lowers `rst_n`. It changes bus inputs only on falling edges. It holds `pad_in` steady around every random register check, so a pin read is compared only after the debounce window has clearly passed. A second instance, built as not retain-capable with the pull-up taken from the data register, takes the same bus traffic as the main instance.

// File: rtl/gpio_port_pkg.sv
// Shared definitions for the GPIO port: the register address map.
// Assumes a two-bit word address; the pin address is read-only.
package gpio_port_pkg;

    typedef enum logic [1:0] {
        REG_DIR  = 2'd0,
        REG_DATA = 2'd1,
        REG_PULL = 2'd2,
        REG_PIN  = 2'd3
    } gpio_reg_e;

endpackage

// File: rtl/gpio_port_regs.sv
// Configuration registers of the port: direction, output data and, when
// present, pull-up. Writes are single-cycle strobes. The reset is synchronous
// and active low. When RETAIN is set and the reset cause is a watchdog
// overflow, the registers hold their contents instead of clearing.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter bit RETAIN  = 1'b1,
    parameter bit HAS_PCR = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_wdt,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] pull_q
);

    logic keep_state;

    // Decide whether the current reset must spare the registers.
    always_comb keep_state = RETAIN && rst_wdt;

    // Direction and data registers with reset classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (!keep_state) begin
                dir_q  <= '0;
                data_q <= '0;
            end
        end else if (wr) begin
            if (addr == REG_DIR)  dir_q  <= wdata;
            if (addr == REG_DATA) data_q <= wdata;
        end
    end

    generate
        if (HAS_PCR) begin : g_pcr
            // Separate pull-up register, reset in the same way.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    if (!keep_state) pull_q <= '0;
                end else if (wr && addr == REG_PULL) begin
                    pull_q <= wdata;
                end
            end
        end else begin : g_no_pcr
            assign pull_q = '0;
        end
    endgenerate

endmodule

// File: rtl/gpio_sync2.sv
// Two-flop synchronizer for a vector of asynchronous pad levels.
// Assumes each bit is independent; no bus coherency across bits is implied.
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta;

    // Two register stages clearing on any reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/gpio_debounce.sv
// Per-pin debounce filter. A shared prescaler gives one sample tick every
// TICK_DIV clocks. A masked pin's output moves to a new level once COUNT
// consecutive ticks have seen that level. Unmasked pins pass straight through.
// Assumes the input is already synchronized, and TICK_DIV >= 2, COUNT >= 1.
module gpio_debounce #(
    parameter int          WIDTH    = 8,
    parameter logic [WIDTH-1:0] MASK = 8'hF0,
    parameter int          COUNT    = 4,
    parameter int          TICK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    localparam int CW = $clog2(COUNT + 1);
    localparam int TW = $clog2(TICK_DIV);
    localparam logic [CW-1:0] CNT_MAX  = CW'(COUNT);
    localparam logic [TW-1:0] TICK_TOP = TW'(TICK_DIV - 1);

    logic [TW-1:0] presc;
    logic          tick;

    // Prescaler generating the shared sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n)              presc <= '0;
        else if (presc == TICK_TOP) presc <= '0;
        else                     presc <= presc + 1'b1;
    end

    always_comb tick = (presc == TICK_TOP);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            if (MASK[i]) begin : g_filt
                logic          last;
                logic [CW-1:0] run;
                logic [CW-1:0] run_next;
                logic          q_r;

                // Length of the run of equal samples after this tick.
                always_comb begin
                    if (d[i] != last)      run_next = CW'(1);
                    else if (run == CNT_MAX) run_next = CNT_MAX;
                    else                   run_next = run + 1'b1;
                end

                // Run tracking and output update on sample ticks.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        last <= 1'b0;
                        run  <= '0;
                        q_r  <= 1'b0;
                    end else if (tick) begin
                        last <= d[i];
                        run  <= run_next;
                        if (run_next == CNT_MAX) q_r <= d[i];
                    end
                end

                assign q[i] = q_r;
            end else begin : g_pass
                assign q[i] = d[i];
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_retain_port.sv
// GPIO port top level. It joins the configuration registers, the pad input
// synchronizer and the debounce filter. It drives the pad controls and
// decodes bus reads. Assumes a synchronous active-low reset, and that
// rst_wdt gives the reset cause while rst_n is low.
module gpio_retain_port
    import gpio_port_pkg::*;
#(
    parameter int               WIDTH     = 8,
    parameter bit               RETAIN    = 1'b1,
    parameter bit               PULL_MODE = 1'b0,
    parameter logic [WIDTH-1:0] DEB_MASK  = 8'hF0,
    parameter int               DEB_COUNT = 4,
    parameter int               TICK_DIV  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rst_wdt,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);

    localparam bit HAS_PCR = !PULL_MODE;

    logic [WIDTH-1:0] dir_q, data_q, pull_q;
    logic [WIDTH-1:0] pin_sync, pin_clean, pin_view, pu_src;

    gpio_port_regs #(
        .WIDTH(WIDTH), .RETAIN(RETAIN), .HAS_PCR(HAS_PCR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .rst_wdt(rst_wdt),
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .dir_q(dir_q), .data_q(data_q), .pull_q(pull_q)
    );

    gpio_sync2 #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    gpio_debounce #(
        .WIDTH(WIDTH), .MASK(DEB_MASK), .COUNT(DEB_COUNT), .TICK_DIV(TICK_DIV)
    ) u_deb (
        .clk(clk), .rst_n(rst_n), .d(pin_sync), .q(pin_clean)
    );

    generate
        if (PULL_MODE) begin : g_pu_data
            assign pu_src = data_q;
        end else begin : g_pu_reg
            assign pu_src = pull_q;
        end
    endgenerate

    // Pad controls: pull-up allowed only on pins in input mode.
    always_comb begin
        pad_out = data_q;
        pad_oe  = dir_q;
        pad_pu  = ~dir_q & pu_src;
    end

    // Pin view: output pins echo their data bit, inputs show the filtered pad.
    always_comb pin_view = (dir_q & data_q) | (~dir_q & pin_clean);

    // Read data decode.
    always_comb begin
        case (bus_addr)
            REG_DIR:  bus_rdata = dir_q;
            REG_DATA: bus_rdata = data_q;
            REG_PULL: bus_rdata = pull_q;
            default:  bus_rdata = pin_view;
        endcase
    end

endmodule

// File: rtl/gpio_retain_port_checker.sv
// Assertion checker for gpio_retain_port, attached by bind. It observes only
// the top-level ports. Assumes rst_wdt is defined whenever rst_n is low.
module gpio_retain_port_checker #(
    parameter int WIDTH  = 8,
    parameter bit RETAIN = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rst_wdt,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [WIDTH-1:0] bus_wdata,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe,
    input logic [WIDTH-1:0] pad_pu
);

    logic seen = 1'b0;

    // Marks that at least one clock edge has passed.
    always_ff @(posedge clk) seen <= 1'b1;

    // R1: power-on reset clears the driven state.
    p_por_clears_r1: assert property (@(posedge clk) disable iff (!seen)
        (!rst_n && !rst_wdt) |=> (pad_oe == '0 && pad_out == '0 && pad_pu == '0));

    // R2: watchdog reset on a retain-capable port keeps the pads.
    p_wdt_keeps_r2: assert property (@(posedge clk) disable iff (!seen)
        (RETAIN && !rst_n && rst_wdt) |=> ($stable(pad_oe) && $stable(pad_out)));

    // R4: output enable follows a direction write.
    p_oe_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=> (pad_oe == $past(bus_wdata)));

    // R5: no pin has its pull-up on while it drives.
    p_pu_off_on_output_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    // R7: a write at the pin address changes no pad control.
    p_pin_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(pad_oe) && $stable(pad_out) && $stable(pad_pu)));

endmodule

bind gpio_retain_port gpio_retain_port_checker #(.WIDTH(WIDTH), .RETAIN(RETAIN)) u_chk (
    .clk(clk), .rst_n(rst_n), .rst_wdt(rst_wdt), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu)
);

// File: tb/gpio_retain_port_test.sv
`timescale 1ns/1ps
module gpio_retain_port_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_wdt = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] rdata_a, out_a, oe_a, pu_a;
    logic [7:0] rdata_b, out_b, oe_b, pu_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference state for both instances.
    logic [7:0] m_dir, m_dat, m_pul, b_dir, b_dat;

    always #2.5 clk = ~clk;

    gpio_retain_port uut (
        .clk(clk), .rst_n(rst_n), .rst_wdt(rst_wdt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .pad_in(pad_in), .pad_out(out_a), .pad_oe(oe_a), .pad_pu(pu_a)
    );

    gpio_retain_port #(.RETAIN(1'b0), .PULL_MODE(1'b1)) uut_b (
        .clk(clk), .rst_n(rst_n), .rst_wdt(rst_wdt), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .pad_in(pad_in), .pad_out(out_b), .pad_oe(oe_b), .pad_pu(pu_b)
    );

    function automatic logic [7:0] exp_view(logic [7:0] d, logic [7:0] o, logic [7:0] p);
        return (d & o) | (~d & p);
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_a(logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #0.5; v = rdata_a;
    endtask

    task automatic rd_b(logic [1:0] a, output logic [7:0] v);
        bus_addr = a; #0.5; v = rdata_b;
    endtask

    task automatic do_reset(logic wdt);
        @(negedge clk);
        rst_wdt = wdt; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; rst_wdt = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_pads(string tag);
        chk({tag, " R4 oe"}, oe_a, m_dir);
        chk({tag, " R4 out"}, out_a, m_dat);
        chk({tag, " R5 pu"}, pu_a, ~m_dir & m_pul);
        chk({tag, " R4 oe_b"}, oe_b, b_dir);
        chk({tag, " R4 out_b"}, out_b, b_dat);
        chk({tag, " R6 pu_b"}, pu_b, ~b_dir & b_dat);
    endtask

    // Watchdog ending a hung run as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [1:0] a;
        logic [7:0] d;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_dir = 0; m_dat = 0; m_pul = 0; b_dir = 0; b_dat = 0;

        // R1: state after power-on reset.
        check_pads("R1 por");
        rd_a(2'd0, v); chk("R1 dir", v, 8'h00);
        rd_a(2'd1, v); chk("R1 data", v, 8'h00);
        rd_a(2'd2, v); chk("R1 pull", v, 8'h00);

        // R3 R4 R5 R6 R7: random register traffic.
        for (int i = 0; i < 80; i++) begin
            a = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            bus_write(a, d);
            case (a)
                2'd0: begin m_dir = d; b_dir = d; end
                2'd1: begin m_dat = d; b_dat = d; end
                2'd2: m_pul = d;
                default: ;
            endcase
            check_pads(a == 2'd3 ? "R7 pin write" : "rand");
            rd_a(2'd0, v); chk("R3 dir", v, m_dir);
            rd_a(2'd1, v); chk("R3 data", v, m_dat);
            rd_a(2'd2, v); chk("R3 pull", v, m_pul);
            rd_b(2'd2, v); chk("R6 pull absent", v, 8'h00);
        end

        // R8: pin reads after a settled input.
        for (int i = 0; i < 10; i++) begin
            d = 8'($urandom);
            bus_write(2'd0, d); m_dir = d; b_dir = d;
            @(negedge clk);
            pad_in = 8'($urandom);
            repeat (40) @(negedge clk);
            rd_a(2'd3, v); chk("R8 pin view", v, exp_view(m_dir, m_dat, pad_in));
            rd_b(2'd3, v); chk("R8 pin view b", v, exp_view(b_dir, b_dat, pad_in));
        end

        // R8 R9: synchronizer latency and debounce delay.
        bus_write(2'd0, 8'h00); m_dir = 0; b_dir = 0;
        pad_in = 8'h00;
        repeat (40) @(negedge clk);
        pad_in = 8'hFF;
        @(negedge clk);
        rd_a(2'd3, v); chk("R8 one edge", v, 8'h00);
        @(negedge clk);
        rd_a(2'd3, v); chk("R9 sync done deb pending", v, 8'h0F);
        repeat (40) @(negedge clk);
        rd_a(2'd3, v); chk("R9 deb accepted", v, 8'hFF);

        // R9: short pulse on debounced pins is rejected.
        pad_in = 8'h00;
        repeat (40) @(negedge clk);
        pad_in = 8'hF0;
        repeat (3) @(negedge clk);
        pad_in = 8'h00;
        repeat (40) @(negedge clk);
        rd_a(2'd3, v); chk("R9 glitch ignored", v, 8'h00);

        // R2: watchdog reset retains on uut, clears on uut_b.
        bus_write(2'd0, 8'hA5); bus_write(2'd1, 8'h3C); bus_write(2'd2, 8'h0F);
        m_dir = 8'hA5; m_dat = 8'h3C; m_pul = 8'h0F; b_dir = 8'hA5; b_dat = 8'h3C;
        check_pads("R2 before");
        do_reset(1'b1);
        b_dir = 0; b_dat = 0;
        check_pads("R2 after wdt");
        rd_a(2'd2, v); chk("R2 pull kept", v, 8'h0F);

        // R1: power-on reset clears the retained state.
        do_reset(1'b0);
        m_dir = 0; m_dat = 0; m_pul = 0;
        check_pads("R1 por after wdt");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule